// File: doc/BRIEF.md
# Multiplexed DRAM-Bus to SRAM Bridge

This block lets a memory controller built for dynamic RAM drive a bank of static RAM without change. The controller presents a 9-bit multiplexed address, first qualified by a row strobe and then by a column strobe. The bridge rebuilds the 18-bit word address from the two phases. Two byte write strobes, one per byte lane, become per-lane SRAM write enables. A read fetches a full 16-bit word. The low byte is handed back while the column strobe is held low. The high byte is caught in a holding register when the column strobe rises, and is presented from there afterwards.

All strobes are active low and asynchronous to the bridge. They are brought into a fast internal clock through synchroniser chains, and the bridge reacts to their synchronised levels. The cycle type is fixed when the column phase starts. If either byte strobe is active then, the cycle is a write. Otherwise it is a read, and no write can happen in it. A row strobe with no column strobe is a refresh and never touches the SRAM. A phase input marks processor periods (high) and video periods (low). The high byte of a read is kept only in a video period.

Top module: `mdram_sram_bridge`

## Requirements
- R1: The row phase value of `mux_addr` appears on `sram_addr[8:0]`, and the column phase value appears on `sram_addr[17:9]`. Both are valid while the column strobe is low.
- R2: After the row strobe returns high, `sram_addr` is zero and `sram_ce_n` is high.
- R3: A refresh cycle (row strobe low with the column strobe kept high) leaves `sram_ce_n`, `sram_oe_n` and both bits of `sram_we_n` high. It leaves `rd_data` unchanged.
- R4: `sram_ce_n` is low only while both the synchronised row strobe and the synchronised column strobe are low.
- R5: In a write cycle, `sram_we_n[0]` is low only while `lo_we_n` is low, and `sram_we_n[1]` is low only while `hi_we_n` is low. `sram_wdata` carries `wdata` on both lanes. The other lane of the addressed word is not changed.
- R6: `sram_oe_n` is low only in a read cycle with both byte strobes high. A byte strobe that falls after the column strobe, in a read cycle, writes nothing. `sram_oe_n` and `sram_we_n` are never active together.
- R7: During a read, while the column strobe is low, `rd_data` equals `sram_rdata[7:0]`, the low byte of the addressed word.
- R8: When the column strobe rises at the end of a read with `phase` low (video period), `sram_rdata[15:8]` is captured. `rd_data` then shows that high byte.
- R9: When the column strobe rises at the end of a read with `phase` high (processor period), the holding register keeps its previous value.
- R10: The held byte on `rd_data` survives write and refresh cycles until the next video read replaces it.
- R11: After reset, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are inactive (high), `sram_addr` is zero and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| lo_we_n | input | 1 | Low byte lane write strobe, active low |
| hi_we_n | input | 1 | High byte lane write strobe, active low |
| phase | input | 1 | 1 = processor period, 0 = video period |
| mux_addr | input | 9 | Multiplexed row/column address |
| wdata | input | 8 | Write byte from the controller |
| rd_data | output | 8 | Read byte to the controller |
| sram_addr | output | 18 | SRAM word address {column, row} |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 2 | SRAM byte-lane write enables, active low, bit 0 = low byte |
| sram_wdata | output | 16 | SRAM write data, write byte on both lanes |
| sram_rdata | input | 16 | SRAM read data |

## Verification
The checker watches, on every cycle, four things:
- output enable and write enables are never active together;
- any write enable implies chip enable;
- chip enable implies both synchronised strobes are low;
- with the row strobe high, the address is zero and the chip is disabled.

It also confirms that `rd_data` stays stable through any stretch with the chip disabled. Address reconstruction, lane selection, capture of the high byte in video periods and retention in processor periods depend on data values. Only the bench scenarios can show those, by comparing them with a scoreboard of the bytes it has written. The late byte strobe in a read cycle and refresh-only cycles are also shown by bench scenarios.

// File: rtl/msb_pkg.sv
package msb_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_ROW  = 2'd1,
    CYC_RD   = 2'd2,
    CYC_WR   = 2'd3
  } cyc_state_e;

  localparam int STB_RAS   = 0;
  localparam int STB_CAS   = 1;
  localparam int STB_WELO  = 2;
  localparam int STB_WEHI  = 3;
  localparam int STB_PHASE = 4;
  localparam int STB_COUNT = 5;
endpackage

// File: rtl/msb_sync.sv
module msb_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync,
  output logic [W-1:0] dly
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign sync = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly <= RST_VAL;
    else        dly <= sync;
  end
endmodule

// File: rtl/msb_addr_capture.sv
module msb_addr_capture #(
  parameter int ROW_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_row,
  input  logic               ld_col,
  input  logic               clr,
  input  logic [ROW_W-1:0]   madr,
  output logic [2*ROW_W-1:0] addr
);
  logic [ROW_W-1:0] row_q, row_d;
  logic [ROW_W-1:0] col_q, col_d;
  logic             upd_en;

  assign upd_en = clr | ld_row | ld_col;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (clr) begin
      row_d = '0;
      col_d = '0;
    end else begin
      if (ld_row) row_d = madr;
      if (ld_col) col_d = madr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (upd_en) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign addr = {col_q, row_q};
endmodule

// File: rtl/msb_cycle_fsm.sv
module msb_cycle_fsm
  import msb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_s,
  input  logic       cas_s,
  input  logic       welo_s,
  input  logic       wehi_s,
  input  logic       phase_s,
  output cyc_state_e state,
  output logic       ld_row,
  output logic       ld_col,
  output logic       clr,
  output logic       cap_hi
);
  cyc_state_e state_d;
  logic       any_we;

  assign any_we = ~welo_s | ~wehi_s;

  always_comb begin
    state_d = state;
    ld_row  = 1'b0;
    ld_col  = 1'b0;
    clr     = 1'b0;
    cap_hi  = 1'b0;
    unique case (state)
      CYC_IDLE: begin
        if (!ras_s) begin
          state_d = CYC_ROW;
          ld_row  = 1'b1;
        end
      end
      CYC_ROW: begin
        if (ras_s) begin
          state_d = CYC_IDLE;
          clr     = 1'b1;
        end else if (!cas_s) begin
          state_d = any_we ? CYC_WR : CYC_RD;
          ld_col  = 1'b1;
        end
      end
      CYC_RD, CYC_WR: begin
        if (ras_s || cas_s) begin
          cap_hi  = (state == CYC_RD) && !phase_s;
          state_d = ras_s ? CYC_IDLE : CYC_ROW;
          clr     = ras_s;
        end
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CYC_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/msb_read_hold.sv
module msb_read_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hold <= '0;
    else if (cap) hold <= din;
  end
endmodule

// File: rtl/mdram_sram_bridge.sv
module mdram_sram_bridge
  import msb_pkg::*;
#(
  parameter int ROW_W       = 9,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                lo_we_n,
  input  logic                hi_we_n,
  input  logic                phase,
  input  logic [ROW_W-1:0]    mux_addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [2*ROW_W-1:0]  sram_addr,
  output logic                sram_ce_n,
  output logic                sram_oe_n,
  output logic [1:0]          sram_we_n,
  output logic [2*BYTE_W-1:0] sram_wdata,
  input  logic [2*BYTE_W-1:0] sram_rdata
);
  localparam int ADDR_W = 2 * ROW_W;
  localparam int WORD_W = 2 * BYTE_W;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  irst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign irst_n = rst_pipe[RST_STAGES-1];

  // strobe synchronisers
  logic [STB_COUNT-1:0] strb_raw, strb_s, strb_d;

  always_comb begin
    strb_raw            = '1;
    strb_raw[STB_RAS]   = ras_n;
    strb_raw[STB_CAS]   = cas_n;
    strb_raw[STB_WELO]  = lo_we_n;
    strb_raw[STB_WEHI]  = hi_we_n;
    strb_raw[STB_PHASE] = phase;
  end

  msb_sync #(
    .W      (STB_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL({STB_COUNT{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(irst_n),
    .din  (strb_raw),
    .sync (strb_s),
    .dly  (strb_d)
  );

  cyc_state_e state;
  logic       ld_row, ld_col, clr, cap_hi;

  msb_cycle_fsm u_fsm (
    .clk    (clk),
    .rst_n  (irst_n),
    .ras_s  (strb_s[STB_RAS]),
    .cas_s  (strb_s[STB_CAS]),
    .welo_s (strb_s[STB_WELO]),
    .wehi_s (strb_s[STB_WEHI]),
    .phase_s(strb_s[STB_PHASE]),
    .state  (state),
    .ld_row (ld_row),
    .ld_col (ld_col),
    .clr    (clr),
    .cap_hi (cap_hi)
  );

  logic [ADDR_W-1:0] addr_q;

  msb_addr_capture #(.ROW_W(ROW_W)) u_addr (
    .clk   (clk),
    .rst_n (irst_n),
    .ld_row(ld_row),
    .ld_col(ld_col),
    .clr   (clr),
    .madr  (mux_addr),
    .addr  (addr_q)
  );

  logic [BYTE_W-1:0] hold_q;

  msb_read_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk  (clk),
    .rst_n(irst_n),
    .cap  (cap_hi),
    .din  (sram_rdata[WORD_W-1:BYTE_W]),
    .hold (hold_q)
  );

  logic col_active, rd_cyc, wr_cyc;

  assign rd_cyc     = (state == CYC_RD);
  assign wr_cyc     = (state == CYC_WR);
  assign col_active = rd_cyc | wr_cyc;

  assign sram_addr    = addr_q;
  assign sram_ce_n    = ~col_active;
  assign sram_oe_n    = ~(rd_cyc & strb_s[STB_WELO] & strb_s[STB_WEHI]);
  assign sram_we_n[0] = ~(wr_cyc & ~strb_s[STB_WELO]);
  assign sram_we_n[1] = ~(wr_cyc & ~strb_s[STB_WEHI]);
  assign sram_wdata   = {wdata, wdata};
  assign rd_data      = rd_cyc ? sram_rdata[BYTE_W-1:0] : hold_q;
endmodule

// File: rtl/msb_checker.sv
module msb_checker #(
  parameter int ADDR_W = 18,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_d,
  input logic              cas_d,
  input logic              ce_n,
  input logic              oe_n,
  input logic [1:0]        we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] rdat
);
  assert_oe_we_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && (we_n != 2'b11)));

  assert_we_needs_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n != 2'b11) |-> !ce_n);

  assert_ce_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> (!ras_d && !cas_d));

  assert_addr_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ras_d |-> ((addr == '0) && ce_n));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && $past(ce_n)) |-> $stable(rdat));
endmodule

bind mdram_sram_bridge msb_checker #(
  .ADDR_W(2 * ROW_W),
  .BYTE_W(BYTE_W)
) u_msb_checker (
  .clk  (clk),
  .rst_n(irst_n),
  .ras_d(strb_d[msb_pkg::STB_RAS]),
  .cas_d(strb_d[msb_pkg::STB_CAS]),
  .ce_n (sram_ce_n),
  .oe_n (sram_oe_n),
  .we_n (sram_we_n),
  .addr (sram_addr),
  .rdat (rd_data)
);

// File: tb/tb_mdram_sram_bridge.sv
module tb_mdram_sram_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, cas_n, lo_we_n, hi_we_n, phase;
  logic [8:0]  mux_addr;
  logic [7:0]  wdata;
  logic [7:0]  rd_data;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_oe_n;
  logic [1:0]  sram_we_n;
  logic [15:0] sram_wdata;
  logic [15:0] sram_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0]  hold_exp;
  logic [15:0] sram_mem [int];
  logic [15:0] exp_mem  [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdram_sram_bridge dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .lo_we_n(lo_we_n), .hi_we_n(hi_we_n), .phase(phase),
    .mux_addr(mux_addr), .wdata(wdata), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  // static RAM model
  always @(posedge clk) begin
    if (!sram_ce_n && (sram_we_n != 2'b11)) begin
      logic [15:0] w;
      w = sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 16'h0000;
      if (!sram_we_n[0]) w[7:0]  = sram_wdata[7:0];
      if (!sram_we_n[1]) w[15:8] = sram_wdata[15:8];
      sram_mem[int'(sram_addr)] = w;
    end
  end

  always @(negedge clk) begin
    if (!sram_ce_n && !sram_oe_n)
      sram_rdata <= sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 16'h0000;
    else
      sram_rdata <= 16'h0000;
  end

  function automatic logic [15:0] exp_word(input logic [17:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  // one access: wr=1 write to lane hi (0 = low lane), else read
  task automatic access(input bit wr, input bit hi, input logic [8:0] row,
                        input logic [8:0] col, input logic [7:0] b, input bit video);
    logic [17:0] a;
    logic [15:0] w;
    a = {col, row};
    phase = ~video;
    mux_addr = row;
    ras_n = 1'b0;
    settle();
    check("R1 row", {23'd0, sram_addr[8:0]}, {23'd0, row});
    check("R3 no enable in row phase", {29'd0, sram_ce_n, sram_we_n}, 32'h7);
    mux_addr = col;
    if (wr) begin
      wdata = b;
      if (hi) hi_we_n = 1'b0; else lo_we_n = 1'b0;
    end
    cas_n = 1'b0;
    settle();
    check("R1 col", {14'd0, sram_addr}, {14'd0, a});
    check("R4 ce low", {31'd0, sram_ce_n}, 32'd0);
    if (wr) begin
      check("R5 lane select", {30'd0, sram_we_n}, hi ? 32'h1 : 32'h2);
      check("R5 data on both lanes", {16'd0, sram_wdata}, {16'd0, b, b});
      check("R6 oe off in write", {31'd0, sram_oe_n}, 32'd1);
      w = exp_word(a);
      if (hi) w[15:8] = b; else w[7:0] = b;
      exp_mem[int'(a)] = w;
    end else begin
      check("R6 oe on in read", {31'd0, sram_oe_n}, 32'd0);
      check("R7 first byte", {24'd0, rd_data}, {24'd0, exp_word(a)[7:0]});
    end
    cas_n = 1'b1; lo_we_n = 1'b1; hi_we_n = 1'b1;
    settle();
    check("R4 ce high after col", {31'd0, sram_ce_n}, 32'd1);
    if (!wr && video) hold_exp = exp_word(a)[15:8];
    if (wr)          check("R10 hold across write", {24'd0, rd_data}, {24'd0, hold_exp});
    else if (video)  check("R8 second byte", {24'd0, rd_data}, {24'd0, hold_exp});
    else             check("R9 processor keeps hold", {24'd0, rd_data}, {24'd0, hold_exp});
    ras_n = 1'b1;
    settle();
    check("R2 release", {13'd0, sram_ce_n, sram_addr}, {13'd0, 1'b1, 18'd0});
  endtask

  task automatic refresh(input logic [8:0] row);
    mux_addr = row;
    ras_n = 1'b0;
    repeat (3) begin
      settle();
      check("R3 refresh no enable", {28'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'hF);
      check("R3 refresh hold", {24'd0, rd_data}, {24'd0, hold_exp});
    end
    ras_n = 1'b1;
    settle();
  endtask

  // read cycle where a byte strobe falls after the column strobe
  task automatic late_strobe(input logic [8:0] row, input logic [8:0] col);
    phase = 1'b1;
    mux_addr = row;
    ras_n = 1'b0;
    settle();
    mux_addr = col;
    cas_n = 1'b0;
    settle();
    wdata = 8'hEE;
    lo_we_n = 1'b0;
    settle();
    check("R6 late strobe no write", {30'd0, sram_we_n}, 32'h3);
    check("R6 late strobe oe off", {31'd0, sram_oe_n}, 32'd1);
    cas_n = 1'b1; lo_we_n = 1'b1;
    settle();
    ras_n = 1'b1;
    settle();
  endtask

  initial begin
    ras_n = 1; cas_n = 1; lo_we_n = 1; hi_we_n = 1; phase = 1;
    mux_addr = '0; wdata = '0; hold_exp = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R11 reset enables", {28'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'hF);
    check("R11 reset addr", {14'd0, sram_addr}, 32'd0);
    check("R11 reset rd_data", {24'd0, rd_data}, 32'd0);

    // directed corners
    access(1, 0, 9'h1FF, 9'h000, 8'hA5, 1);
    access(1, 1, 9'h1FF, 9'h000, 8'h3C, 1);
    access(0, 0, 9'h1FF, 9'h000, 8'h00, 1);  // video read -> hold 3C
    access(1, 0, 9'h000, 9'h1FF, 8'h81, 1);
    refresh(9'h155);
    access(0, 0, 9'h000, 9'h1FF, 8'h00, 0);  // processor read, hold stays
    late_strobe(9'h1FF, 9'h000);
    access(0, 0, 9'h1FF, 9'h000, 8'h00, 1);  // A5 intact after late strobe

    // constrained random traffic over a small address set
    void'($urandom(32'hC0C0_0512));
    for (int i = 0; i < 60; i++) begin
      int k;
      logic [8:0] r, c;
      r = {7'($urandom), 2'($urandom)} & 9'h103;
      c = {7'($urandom), 2'($urandom)} & 9'h181;
      k = $urandom % 5;
      if (k == 4) refresh(r);
      else access(k < 2, k == 1, r, c, 8'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule